// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block is a circular retirement queue that sits beside a pipeline whose functional units may finish in any order. Decode claims a slot at the tail for every instruction in program order and receives a tag naming that slot. A finishing unit posts its result, a secondary address field and an exception flag into the slot named by its tag. Nothing reaches architectural state at that point.

Only the oldest slot may leave the queue, and only once its result has arrived. A finished register-writing slot drives the register-file write port, a finished store drives the store port, and a finished branch leaves with no write. If the oldest slot carries an exception flag, the block raises a trap with that instruction's PC and empties the whole queue in the same cycle. When the trap is seen, every older instruction has already left and no younger one has. A tag-indexed lookup port lets operand read logic fetch a finished but not yet retired value alongside the register file.

Top module: `rob_top`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we`, `st_we`, `trap_valid` and `rd_hit` are 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` high at a clock edge) returns the current `alloc_tag`, and tags are handed out as 0, 1, 2, … modulo DEPTH.
- R3: When DEPTH slots are held, `alloc_ready` is 0 and an `alloc_valid` request claims no slot and leaves `alloc_tag` unchanged.
- R4: A completion stores its value only in its slot. No write port fires for it while an older slot has not finished.
- R5: At most one slot retires per cycle, always the oldest. A finished `alloc_kind` 2'b00 (register) slot without exception drives `rf_we` with its destination on `rf_waddr` and its result on `rf_wdata`.
- R6: A finished `alloc_kind` 2'b01 (store) slot drives `st_we`, with `cmp_addr` on `st_addr` and `cmp_value` on `st_data`. A finished kind 2'b10 (branch) slot retires with no write, and `cmp_addr` holds its target.
- R7: When the oldest slot has finished with `cmp_exc` set, `trap_valid` is 1 with that slot's PC on `trap_pc` and no write port fires. After the edge the queue is empty, `alloc_tag` is 0 and no younger slot ever retires.
- R8: A completion whose tag names a slot not currently held is ignored. A later allocation of that slot starts unfinished.
- R9: `rd_hit` is 1 exactly when the slot named by `rd_tag` is held, finished and free of exception, with its result on `rd_value`, in the same cycle.
- R10: In a trap cycle `alloc_ready` is 0 and an allocation request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_kind | input | 2 | 00 register write, 01 store, 10 branch |
| alloc_dest | input | AREG_W | Destination register ID |
| alloc_pc | input | PC_W | Instruction PC |
| alloc_ready | output | 1 | A slot can be claimed this cycle |
| alloc_tag | output | IDX_W | Tag of the slot claimed this cycle |
| cmp_valid | input | 1 | A unit reports completion |
| cmp_tag | input | IDX_W | Slot being completed |
| cmp_value | input | XLEN | Result value or store data |
| cmp_addr | input | XLEN | Store address or branch target |
| cmp_exc | input | 1 | Instruction raised an exception |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | AREG_W | Register-file write address |
| rf_wdata | output | XLEN | Register-file write data |
| st_we | output | 1 | Store port write enable |
| st_addr | output | XLEN | Store address |
| st_data | output | XLEN | Store data |
| trap_valid | output | 1 | Precise exception, queue flushed |
| trap_pc | output | PC_W | PC of the faulting instruction |
| rd_tag | input | IDX_W | Lookup slot |
| rd_hit | output | 1 | Lookup slot holds a finished value |
| rd_value | output | XLEN | Value of the lookup slot |

## Verification
The bench builds the block with DEPTH 4, XLEN 16 and PC_W 16. With only four slots, the random stream fills the queue and wraps the tag pointers many times. It therefore keeps hitting the full-queue stall, tag reuse after a flush and completions aimed at freed slots. The directed preamble sets up out-of-order finishes behind an unfinished head, one retirement of each kind, and a trap that coincides with an allocation request.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10,
    KIND_RSVD   = 2'b11
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (flush_i) begin
      head_d = '0;
      tail_d = '0;
    end else begin
      if (pop_i)  head_d = head_q + PTR_W'(1);
      if (push_i) tail_d = tail_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_o  = head_q[IDX_W-1:0];
  assign tail_o  = tail_q[IDX_W-1:0];
  assign full_o  = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) && (head_q[IDX_W] != tail_q[IDX_W]);
  assign empty_o = (head_q == tail_q);

  assert_full_holds_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !flush_i) |=> $stable(tail_q))
    else $error("tail moved while full");

  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !pop_i)
    else $error("retire from empty queue");
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int XLEN   = 32,
  parameter int AREG_W = 5,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              alloc_we_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  rob_kind_e         alloc_kind_i,
  input  logic [AREG_W-1:0] alloc_dest_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  input  logic              cmp_we_i,
  input  logic [IDX_W-1:0]  cmp_idx_i,
  input  logic [XLEN-1:0]   cmp_value_i,
  input  logic [XLEN-1:0]   cmp_addr_i,
  input  logic              cmp_exc_i,
  input  logic              retire_we_i,
  input  logic [IDX_W-1:0]  head_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              head_valid_o,
  output logic              head_done_o,
  output logic              head_exc_o,
  output rob_kind_e         head_kind_o,
  output logic [AREG_W-1:0] head_dest_o,
  output logic [XLEN-1:0]   head_value_o,
  output logic [XLEN-1:0]   head_addr_o,
  output logic [PC_W-1:0]   head_pc_o,
  output logic              rd_ready_o,
  output logic [XLEN-1:0]   rd_value_o
);
  logic [DEPTH-1:0]  valid_vec, done_vec, exc_vec;
  rob_kind_e         kind_arr  [DEPTH];
  logic [AREG_W-1:0] dest_arr  [DEPTH];
  logic [XLEN-1:0]   value_arr [DEPTH];
  logic [XLEN-1:0]   addr_arr  [DEPTH];
  logic [PC_W-1:0]   pc_arr    [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic v_q, v_d, d_q, d_d, e_q, e_d;
    logic hit_alloc, hit_cmp, hit_ret;
    rob_kind_e         kind_q;
    logic [AREG_W-1:0] dest_q;
    logic [XLEN-1:0]   value_q, addr_q;
    logic [PC_W-1:0]   pc_q;

    assign hit_alloc = alloc_we_i  && (alloc_idx_i == IDX_W'(i));
    assign hit_cmp   = cmp_we_i    && (cmp_idx_i   == IDX_W'(i)) && v_q;
    assign hit_ret   = retire_we_i && (head_idx_i  == IDX_W'(i));

    always_comb begin
      v_d = v_q;
      d_d = d_q;
      e_d = e_q;
      if (flush_i) begin
        v_d = 1'b0;
        d_d = 1'b0;
        e_d = 1'b0;
      end else begin
        if (hit_ret) begin
          v_d = 1'b0;
          d_d = 1'b0;
          e_d = 1'b0;
        end
        if (hit_alloc) begin
          v_d = 1'b1;
          d_d = 1'b0;
          e_d = 1'b0;
        end
        if (hit_cmp) begin
          d_d = 1'b1;
          e_d = cmp_exc_i;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        e_q <= 1'b0;
      end else begin
        v_q <= v_d;
        d_q <= d_d;
        e_q <= e_d;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) begin
        kind_q <= alloc_kind_i;
        dest_q <= alloc_dest_i;
        pc_q   <= alloc_pc_i;
      end
      if (hit_cmp) begin
        value_q <= cmp_value_i;
        addr_q  <= cmp_addr_i;
      end
    end

    assign valid_vec[i] = v_q;
    assign done_vec[i]  = d_q;
    assign exc_vec[i]   = e_q;
    assign kind_arr[i]  = kind_q;
    assign dest_arr[i]  = dest_q;
    assign value_arr[i] = value_q;
    assign addr_arr[i]  = addr_q;
    assign pc_arr[i]    = pc_q;
  end

  assign head_valid_o = valid_vec[head_idx_i];
  assign head_done_o  = done_vec[head_idx_i];
  assign head_exc_o   = exc_vec[head_idx_i];
  assign head_kind_o  = kind_arr[head_idx_i];
  assign head_dest_o  = dest_arr[head_idx_i];
  assign head_value_o = value_arr[head_idx_i];
  assign head_addr_o  = addr_arr[head_idx_i];
  assign head_pc_o    = pc_arr[head_idx_i];
  assign rd_ready_o   = valid_vec[rd_idx_i] && done_vec[rd_idx_i] && !exc_vec[rd_idx_i];
  assign rd_value_o   = value_arr[rd_idx_i];

  assert_alloc_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_we_i && !flush_i) |=> (valid_vec[$past(alloc_idx_i)] && !done_vec[$past(alloc_idx_i)]))
    else $error("allocated slot not fresh");

  assert_retired_slot_freed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_we_i |=> !valid_vec[$past(head_idx_i)])
    else $error("retired slot still held");

  assert_stray_cmp_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we_i && !valid_vec[cmp_idx_i]) |=> !done_vec[$past(cmp_idx_i)])
    else $error("completion to free slot took effect");
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int XLEN   = 32,
  parameter int AREG_W = 5,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [AREG_W-1:0] alloc_dest,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic [XLEN-1:0]   cmp_value,
  input  logic [XLEN-1:0]   cmp_addr,
  input  logic              cmp_exc,
  output logic              rf_we,
  output logic [AREG_W-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              st_we,
  output logic [XLEN-1:0]   st_addr,
  output logic [XLEN-1:0]   st_data,
  output logic              trap_valid,
  output logic [PC_W-1:0]   trap_pc,
  input  logic [IDX_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [XLEN-1:0]   rd_value
);
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              full, empty, push, retire, head_fin;
  logic              head_valid, head_done, head_exc;
  rob_kind_e         head_kind;
  logic [AREG_W-1:0] head_dest;
  logic [XLEN-1:0]   head_value, head_addr;
  logic [PC_W-1:0]   head_pc;

  assign head_fin    = head_valid && head_done;
  assign trap_valid  = head_fin && head_exc;
  assign retire      = head_fin && !head_exc;
  assign alloc_ready = !full && !trap_valid;
  assign push        = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_idx;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .pop_i   (retire),
    .flush_i (trap_valid),
    .head_o  (head_idx),
    .tail_o  (tail_idx),
    .full_o  (full),
    .empty_o (empty)
  );

  rob_entry_store #(
    .DEPTH(DEPTH), .XLEN(XLEN), .AREG_W(AREG_W), .PC_W(PC_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (trap_valid),
    .alloc_we_i   (push),
    .alloc_idx_i  (tail_idx),
    .alloc_kind_i (rob_kind_e'(alloc_kind)),
    .alloc_dest_i (alloc_dest),
    .alloc_pc_i   (alloc_pc),
    .cmp_we_i     (cmp_valid),
    .cmp_idx_i    (cmp_tag),
    .cmp_value_i  (cmp_value),
    .cmp_addr_i   (cmp_addr),
    .cmp_exc_i    (cmp_exc),
    .retire_we_i  (retire),
    .head_idx_i   (head_idx),
    .rd_idx_i     (rd_tag),
    .head_valid_o (head_valid),
    .head_done_o  (head_done),
    .head_exc_o   (head_exc),
    .head_kind_o  (head_kind),
    .head_dest_o  (head_dest),
    .head_value_o (head_value),
    .head_addr_o  (head_addr),
    .head_pc_o    (head_pc),
    .rd_ready_o   (rd_hit),
    .rd_value_o   (rd_value)
  );

  assign rf_we    = retire && (head_kind == KIND_REG);
  assign rf_waddr = head_dest;
  assign rf_wdata = head_value;
  assign st_we    = retire && (head_kind == KIND_STORE);
  assign st_addr  = head_addr;
  assign st_data  = head_value;
  assign trap_pc  = head_pc;

  assert_single_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_we, trap_valid}))
    else $error("more than one retirement action");

  assert_trap_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (empty && (alloc_tag == '0) && !rf_we && !st_we && !trap_valid))
    else $error("queue not empty after trap");

  assert_trap_blocks_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !push)
    else $error("allocation during trap");
endmodule

// File: tb/rob_top_bench.sv
module rob_top_bench;
  localparam int DEPTH = 4;
  localparam int XLEN  = 16;
  localparam int AW    = 5;
  localparam int PCW   = 16;
  localparam int IW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            alloc_valid, cmp_valid, cmp_exc;
  logic [1:0]      alloc_kind;
  logic [AW-1:0]   alloc_dest;
  logic [PCW-1:0]  alloc_pc;
  logic [IW-1:0]   cmp_tag, rd_tag;
  logic [XLEN-1:0] cmp_value, cmp_addr;
  logic            alloc_ready, rf_we, st_we, trap_valid, rd_hit;
  logic [IW-1:0]   alloc_tag;
  logic [AW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata, st_addr, st_data, rd_value;
  logic [PCW-1:0]  trap_pc;

  rob_top #(.DEPTH(DEPTH), .XLEN(XLEN), .AREG_W(AW), .PC_W(PCW)) u_rob_top (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .alloc_pc(alloc_pc), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .cmp_addr(cmp_addr), .cmp_exc(cmp_exc),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
    .trap_valid(trap_valid), .trap_pc(trap_pc),
    .rd_tag(rd_tag), .rd_hit(rd_hit), .rd_value(rd_value)
  );

  int n_run = 0;
  int n_fail = 0;

  // reference model
  logic            m_v [DEPTH];
  logic            m_d [DEPTH];
  logic            m_e [DEPTH];
  logic [1:0]      m_k [DEPTH];
  logic [AW-1:0]   m_dst [DEPTH];
  logic [XLEN-1:0] m_val [DEPTH];
  logic [XLEN-1:0] m_adr [DEPTH];
  logic [PCW-1:0]  m_pc [DEPTH];
  int m_head = 0;
  int m_tail = 0;
  int m_cnt  = 0;

  function automatic logic exp_fin();
    return m_v[m_head] && m_d[m_head];
  endfunction
  function automatic logic exp_trap();
    return exp_fin() && m_e[m_head];
  endfunction
  function automatic logic exp_retire();
    return exp_fin() && !m_e[m_head];
  endfunction
  function automatic logic exp_ready();
    return (m_cnt < DEPTH) && !exp_trap();
  endfunction
  function automatic logic exp_hit(input int t);
    return m_v[t] && m_d[t] && !m_e[t];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 1'b0; alloc_kind = 2'b00; alloc_dest = '0; alloc_pc = '0;
    cmp_valid = 1'b0; cmp_tag = '0; cmp_value = '0; cmp_addr = '0; cmp_exc = 1'b0;
  endtask

  task automatic check_outputs();
    chk("R3 R10", "alloc_ready", 32'(alloc_ready), 32'(exp_ready()));
    chk("R2", "alloc_tag", 32'(alloc_tag), 32'(m_tail));
    chk("R4 R5", "rf_we", 32'(rf_we), 32'(exp_retire() && m_k[m_head] == 2'b00));
    if (exp_retire() && m_k[m_head] == 2'b00) begin
      chk("R5", "rf_waddr", 32'(rf_waddr), 32'(m_dst[m_head]));
      chk("R5", "rf_wdata", 32'(rf_wdata), 32'(m_val[m_head]));
    end
    chk("R4 R6", "st_we", 32'(st_we), 32'(exp_retire() && m_k[m_head] == 2'b01));
    if (exp_retire() && m_k[m_head] == 2'b01) begin
      chk("R6", "st_addr", 32'(st_addr), 32'(m_adr[m_head]));
      chk("R6", "st_data", 32'(st_data), 32'(m_val[m_head]));
    end
    chk("R7", "trap_valid", 32'(trap_valid), 32'(exp_trap()));
    if (exp_trap()) chk("R7", "trap_pc", 32'(trap_pc), 32'(m_pc[m_head]));
    chk("R8 R9", "rd_hit", 32'(rd_hit), 32'(exp_hit(int'(rd_tag))));
    if (exp_hit(int'(rd_tag))) chk("R9", "rd_value", 32'(rd_value), 32'(m_val[rd_tag]));
  endtask

  task automatic model_edge();
    logic t, r, acc;
    t = exp_trap();
    r = exp_retire();
    acc = alloc_valid && exp_ready();
    if (t) begin
      for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_d[i] = 0; m_e[i] = 0; end
      m_head = 0; m_tail = 0; m_cnt = 0;
    end else begin
      if (r) begin
        m_v[m_head] = 0; m_d[m_head] = 0; m_e[m_head] = 0;
        m_head = (m_head + 1) % DEPTH; m_cnt--;
      end
      if (cmp_valid && m_v[cmp_tag] && !(r && int'(cmp_tag) == (m_head + DEPTH - 1) % DEPTH)) begin
        m_d[cmp_tag] = 1; m_e[cmp_tag] = cmp_exc;
        m_val[cmp_tag] = cmp_value; m_adr[cmp_tag] = cmp_addr;
      end
      if (acc) begin
        m_v[m_tail] = 1; m_d[m_tail] = 0; m_e[m_tail] = 0;
        m_k[m_tail] = alloc_kind; m_dst[m_tail] = alloc_dest; m_pc[m_tail] = alloc_pc;
        m_tail = (m_tail + 1) % DEPTH; m_cnt++;
      end
    end
  endtask

  // inputs are set at a negedge; this checks, takes the edge, returns at the next negedge
  task automatic cycle();
    #1;
    check_outputs();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic do_alloc(input logic [1:0] k, input logic [AW-1:0] d, input logic [PCW-1:0] pc);
    idle(); alloc_valid = 1; alloc_kind = k; alloc_dest = d; alloc_pc = pc; cycle();
  endtask

  task automatic do_cmp(input int t, input logic [XLEN-1:0] v, input logic [XLEN-1:0] a, input logic e);
    idle(); cmp_valid = 1; cmp_tag = IW'(t); cmp_value = v; cmp_addr = a; cmp_exc = e; cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250517));
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_d[i] = 0; m_e[i] = 0; end
    idle(); rd_tag = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    chk("R1", "alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R1", "alloc_tag", 32'(alloc_tag), 32'd0);
    chk("R1", "rf_we", 32'(rf_we), 32'd0);
    chk("R1", "st_we", 32'(st_we), 32'd0);
    chk("R1", "trap_valid", 32'(trap_valid), 32'd0);
    chk("R1", "rd_hit", 32'(rd_hit), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // fill the queue: reg, store, branch, reg (R2)
    do_alloc(2'b00, 5'd3, 16'h0100);
    do_alloc(2'b01, 5'd0, 16'h0104);
    do_alloc(2'b10, 5'd0, 16'h0108);
    do_alloc(2'b00, 5'd7, 16'h010C);
    // R3: request while full
    do_alloc(2'b00, 5'd9, 16'h0110);
    // R4: younger ones finish first, nothing retires
    do_cmp(2, 16'h0000, 16'h0200, 0);
    do_cmp(1, 16'hBEEF, 16'h0040, 0);
    idle(); rd_tag = 2'd1; cycle();
    // head finishes: R5, R6 in order over next cycles
    do_cmp(0, 16'h1111, 16'h0000, 0);
    idle(); rd_tag = 2'd0; cycle();
    idle(); cycle();
    idle(); cycle();
    idle(); cycle();
    // R8: completion to freed slot 0, then reuse it
    do_cmp(0, 16'h2222, 16'h0000, 0);
    idle(); alloc_valid = 1; alloc_kind = 2'b00; alloc_dest = 5'd4; alloc_pc = 16'h0114; rd_tag = 2'd0; cycle();
    idle(); cycle();
    // R7: head (tag 3) faults while slot 0 younger finishes
    do_cmp(0, 16'h3333, 16'h0000, 0);
    do_cmp(3, 16'h4444, 16'h0000, 1);
    // R10: allocation requested during trap cycle
    idle(); alloc_valid = 1; alloc_pc = 16'h0118; cycle();
    idle(); cycle();

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      int t;
      idle();
      rd_tag = IW'($urandom_range(DEPTH - 1));
      if ($urandom_range(99) < 60) begin
        alloc_valid = 1;
        alloc_kind = 2'($urandom_range(2));
        alloc_dest = AW'($urandom);
        alloc_pc = PCW'($urandom);
      end
      t = $urandom_range(DEPTH - 1);
      if (m_v[t] && !m_d[t] && $urandom_range(99) < 70) begin
        cmp_valid = 1; cmp_tag = IW'(t);
        cmp_value = XLEN'($urandom); cmp_addr = XLEN'($urandom);
        cmp_exc = ($urandom_range(99) < 4);
      end else if (!m_v[t] && $urandom_range(99) < 20) begin
        cmp_valid = 1; cmp_tag = IW'(t);
        cmp_value = XLEN'($urandom); cmp_addr = XLEN'($urandom);
      end
      cycle();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule